// File: doc/BRIEF.md
# Debug Pin Acknowledge and Timing-Reference Controller

This block sits on the target side of a single-wire, open-drain debug link. It decides when to pull the shared pin low as a handshake acknowledge, and it answers the host's timing-reference request with a pulse of known length. Decoded command strobes and CPU status events come in from neighbouring logic. Two enables go out: one pulls the pin low, the other drives it briefly high. All timing is counted in serial clock cycles.

Acknowledge generation is off after reset. An enable-ack command turns it on and answers with a pulse of its own. A disable-ack command turns it off again. While it is on, each data or run-control command waits for its own completion event and then raises one acknowledge. When the host holds the pin low for long enough and then releases it, any run-control acknowledge still waiting is dropped and a timed reference reply is sent.

Top module: `dbg_ack_ctrl`

## Requirements
- R1: After reset both pin enables are low and acknowledge generation is off. While it is off, read, write and run-control commands and their completion events produce no pulse.
- R2: `cmd_ack_on` turns generation on and produces one acknowledge pulse by itself. `cmd_ack_off` turns generation off, so later commands produce no pulse.
- R3: An acknowledge pulse holds `drv_low` for ACK_LOW cycles, then `drv_high` for one cycle, then releases the pin. `drv_low` first reads high in the cycle after the clock edge that follows the edge sampling the completion event.
- R4: A pending read acknowledges on `bus_done`.
- R5: A pending write acknowledges only when both `wr_data_done` and `bus_done` have been seen since the command. They may come in either order or together.
- R6: A pending background command acknowledges on `cpu_enter_bg`. A pending go command acknowledges on `cpu_exit_bg`.
- R7: A pending go-until ignores `cpu_enter_bg` until it has seen `cpu_exit_bg`, and acknowledges on the next `cpu_enter_bg` after that. A pending trace-one acknowledges on `cpu_enter_bg`.
- R8: A timing-reference request is recognised when the pin is high on a clock edge after at least SYNC_LOW_MIN consecutive low samples, taken while the block is idle. It cancels any pending background, go, go-until or trace-one acknowledge.
- R9: A low period of fewer than SYNC_LOW_MIN samples causes no reply and leaves a pending acknowledge in place.
- R10: The reference reply starts SYNC_WAIT cycles after recognition. It holds `drv_low` for SYNC_REPLY cycles, then `drv_high` for one cycle, then releases the pin.
- R11: `drv_low` and `drv_high` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ack_on | input | 1 | Enable-acknowledge command strobe |
| cmd_ack_off | input | 1 | Disable-acknowledge command strobe |
| cmd_read | input | 1 | Read command strobe |
| cmd_write | input | 1 | Write command strobe |
| cmd_bkgd | input | 1 | Enter-background command strobe |
| cmd_go | input | 1 | Resume command strobe |
| cmd_go_until | input | 1 | Resume-until-halt command strobe |
| cmd_trace1 | input | 1 | Single-step command strobe |
| wr_data_done | input | 1 | All write data has arrived over the pin |
| bus_done | input | 1 | Data bus cycle finished |
| cpu_enter_bg | input | 1 | CPU entered background mode |
| cpu_exit_bg | input | 1 | CPU left background mode |
| pin_in | input | 1 | Sampled debug pin level |
| drv_low | output | 1 | Pull pin low |
| drv_high | output | 1 | Drive pin high (speedup) |

## Verification
The bench builds the block with SYNC_LOW_MIN=10, ACK_LOW=4, SYNC_WAIT=3 and SYNC_REPLY=10, not the defaults of 128/16/16/128. With these values the exact threshold of the long-low detector can be probed on both sides: lows of 9 and 10 samples. A reference reply and its abort of a pending acknowledge also fit in a few dozen cycles. The pulse-length checker covers both pulse lengths at once, because the values differ.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

   typedef enum logic [2:0] {
      PK_NONE, PK_READ, PK_WRITE, PK_BKGD,
      PK_GO, PK_GOU_RUN, PK_GOU_WAIT, PK_TRACE
   } pend_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_ACK_LO, SQ_ACK_HI, SQ_WAIT, SQ_REF_LO, SQ_REF_HI
   } seq_e;

   function automatic logic is_runctl(pend_e k);
      return (k == PK_BKGD) || (k == PK_GO) || (k == PK_GOU_RUN) ||
             (k == PK_GOU_WAIT) || (k == PK_TRACE);
   endfunction

   function automatic int max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/dbg_ack_track.sv
module dbg_ack_track
   import dbg_ack_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_ack_on,
   input  logic cmd_ack_off,
   input  logic cmd_read,
   input  logic cmd_write,
   input  logic cmd_bkgd,
   input  logic cmd_go,
   input  logic cmd_go_until,
   input  logic cmd_trace1,
   input  logic wr_data_done,
   input  logic bus_done,
   input  logic cpu_enter_bg,
   input  logic cpu_exit_bg,
   input  logic ref_hit,
   input  logic ack_take,
   output logic ack_want
);

   logic  en_q;
   pend_e kind_q, kind_n;
   logic  wr_seen_q, bus_seen_q, wr_seen_n, bus_seen_n;
   logic  want_q, fire;
   logic  any_cmd;

   assign any_cmd = cmd_read | cmd_write | cmd_bkgd | cmd_go |
                    cmd_go_until | cmd_trace1;

   always_comb begin
      kind_n     = kind_q;
      wr_seen_n  = wr_seen_q;
      bus_seen_n = bus_seen_q;
      fire       = 1'b0;
      if (en_q && any_cmd) begin
         wr_seen_n  = 1'b0;
         bus_seen_n = 1'b0;
         if      (cmd_read)     kind_n = PK_READ;
         else if (cmd_write)    kind_n = PK_WRITE;
         else if (cmd_bkgd)     kind_n = PK_BKGD;
         else if (cmd_go)       kind_n = PK_GO;
         else if (cmd_go_until) kind_n = PK_GOU_RUN;
         else                   kind_n = PK_TRACE;
      end else if (ref_hit && is_runctl(kind_q)) begin
         kind_n = PK_NONE;
      end else begin
         unique case (kind_q)
            PK_READ: if (bus_done) begin
               fire = 1'b1; kind_n = PK_NONE;
            end
            PK_WRITE: begin
               wr_seen_n  = wr_seen_q | wr_data_done;
               bus_seen_n = bus_seen_q | bus_done;
               if (wr_seen_n && bus_seen_n) begin
                  fire = 1'b1; kind_n = PK_NONE;
               end
            end
            PK_BKGD, PK_GOU_WAIT, PK_TRACE: if (cpu_enter_bg) begin
               fire = 1'b1; kind_n = PK_NONE;
            end
            PK_GO: if (cpu_exit_bg) begin
               fire = 1'b1; kind_n = PK_NONE;
            end
            PK_GOU_RUN: if (cpu_exit_bg) kind_n = PK_GOU_WAIT;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         kind_q     <= PK_NONE;
         wr_seen_q  <= 1'b0;
         bus_seen_q <= 1'b0;
         want_q     <= 1'b0;
      end else begin
         if (cmd_ack_on)       en_q <= 1'b1;
         else if (cmd_ack_off) en_q <= 1'b0;
         kind_q     <= kind_n;
         wr_seen_q  <= wr_seen_n;
         bus_seen_q <= bus_seen_n;
         want_q     <= (want_q & ~ack_take) | fire | cmd_ack_on;
      end
   end

   assign ack_want = want_q;

endmodule

// File: rtl/dbg_sync_detect.sv
module dbg_sync_detect #(
   parameter int SYNC_LOW_MIN = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic seq_idle,
   output logic ref_hit
);

   localparam int LW = $clog2(SYNC_LOW_MIN + 1);
   localparam logic [LW-1:0] LMAX = LW'(SYNC_LOW_MIN);

   logic [LW-1:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_q <= '0;
      else if (!seq_idle || pin_in) low_q <= '0;
      else if (low_q != LMAX)    low_q <= low_q + 1'b1;
   end

   assign ref_hit = seq_idle & pin_in & (low_q == LMAX);

endmodule

// File: rtl/dbg_pulse_seq.sv
module dbg_pulse_seq
   import dbg_ack_pkg::*;
#(
   parameter int ACK_LOW    = 16,
   parameter int SYNC_WAIT  = 16,
   parameter int SYNC_REPLY = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_want,
   input  logic ref_hit,
   output logic seq_idle,
   output logic ack_take,
   output logic drv_low,
   output logic drv_high
);

   localparam int CW = $clog2(max3(ACK_LOW, SYNC_WAIT, SYNC_REPLY) + 1);

   seq_e          st_q;
   logic [CW-1:0] cnt_q;

   assign seq_idle = (st_q == SQ_IDLE);
   assign ack_take = seq_idle & ack_want & ~ref_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE:
               if (ref_hit) begin
                  st_q  <= SQ_WAIT;
                  cnt_q <= CW'(SYNC_WAIT - 1);
               end else if (ack_want) begin
                  st_q  <= SQ_ACK_LO;
                  cnt_q <= CW'(ACK_LOW - 1);
               end
            SQ_ACK_LO:
               if (cnt_q == '0) st_q <= SQ_ACK_HI;
               else             cnt_q <= cnt_q - 1'b1;
            SQ_WAIT:
               if (cnt_q == '0) begin
                  st_q  <= SQ_REF_LO;
                  cnt_q <= CW'(SYNC_REPLY - 1);
               end else cnt_q <= cnt_q - 1'b1;
            SQ_REF_LO:
               if (cnt_q == '0) st_q <= SQ_REF_HI;
               else             cnt_q <= cnt_q - 1'b1;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign drv_low  = (st_q == SQ_ACK_LO) || (st_q == SQ_REF_LO);
   assign drv_high = (st_q == SQ_ACK_HI) || (st_q == SQ_REF_HI);

endmodule

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl #(
   parameter int SYNC_LOW_MIN = 128,
   parameter int ACK_LOW      = 16,
   parameter int SYNC_WAIT    = 16,
   parameter int SYNC_REPLY   = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_ack_on,
   input  logic cmd_ack_off,
   input  logic cmd_read,
   input  logic cmd_write,
   input  logic cmd_bkgd,
   input  logic cmd_go,
   input  logic cmd_go_until,
   input  logic cmd_trace1,
   input  logic wr_data_done,
   input  logic bus_done,
   input  logic cpu_enter_bg,
   input  logic cpu_exit_bg,
   input  logic pin_in,
   output logic drv_low,
   output logic drv_high
);

   if (SYNC_LOW_MIN < 2) begin : g_bad_min
      $error("SYNC_LOW_MIN must be at least 2");
   end
   if (ACK_LOW < 1 || SYNC_WAIT < 1 || SYNC_REPLY < 1) begin : g_bad_len
      $error("pulse lengths must be at least 1");
   end

   logic ack_want, ack_take, ref_hit, seq_idle;

   dbg_ack_track u_track (
      .clk(clk), .rst_n(rst_n),
      .cmd_ack_on(cmd_ack_on), .cmd_ack_off(cmd_ack_off),
      .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_bkgd(cmd_bkgd),
      .cmd_go(cmd_go), .cmd_go_until(cmd_go_until), .cmd_trace1(cmd_trace1),
      .wr_data_done(wr_data_done), .bus_done(bus_done),
      .cpu_enter_bg(cpu_enter_bg), .cpu_exit_bg(cpu_exit_bg),
      .ref_hit(ref_hit), .ack_take(ack_take), .ack_want(ack_want)
   );

   dbg_sync_detect #(.SYNC_LOW_MIN(SYNC_LOW_MIN)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .seq_idle(seq_idle),
      .ref_hit(ref_hit)
   );

   dbg_pulse_seq #(.ACK_LOW(ACK_LOW), .SYNC_WAIT(SYNC_WAIT),
                   .SYNC_REPLY(SYNC_REPLY)) u_seq (
      .clk(clk), .rst_n(rst_n), .ack_want(ack_want), .ref_hit(ref_hit),
      .seq_idle(seq_idle), .ack_take(ack_take),
      .drv_low(drv_low), .drv_high(drv_high)
   );

endmodule

// File: rtl/dbg_ack_ctrl_chk.sv
module dbg_ack_ctrl_chk #(
   parameter int ACK_LOW    = 16,
   parameter int SYNC_REPLY = 128
) (
   input logic clk,
   input logic rst_n,
   input logic drv_low,
   input logic drv_high
);

   logic [15:0] lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lo_run <= '0;
      else if (drv_low) lo_run <= lo_run + 1'b1;
      else              lo_run <= '0;
   end

   // R11
   no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(drv_low && drv_high));

   // R3
   speedup_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_low) |-> drv_high);

   // R10
   release_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_high |=> (!drv_high && !drv_low));

   // R3
   low_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_low && lo_run != 16'd0) |->
         (lo_run == 16'(ACK_LOW) || lo_run == 16'(SYNC_REPLY)));

endmodule

bind dbg_ack_ctrl dbg_ack_ctrl_chk #(.ACK_LOW(ACK_LOW), .SYNC_REPLY(SYNC_REPLY)) u_chk (
   .clk(clk), .rst_n(rst_n), .drv_low(drv_low), .drv_high(drv_high)
);

// File: tb/sim_dbg_ack_ctrl.sv
module sim_dbg_ack_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int P_MIN   = 10;
   localparam int P_ACK   = 4;
   localparam int P_WAIT  = 3;
   localparam int P_REPLY = 10;

   logic clk = 0, rst_n = 0;
   logic c_on = 0, c_off = 0, c_rd = 0, c_wr = 0, c_bk = 0, c_go = 0, c_gu = 0, c_tr = 0;
   logic e_wr = 0, e_bus = 0, e_in = 0, e_out = 0;
   logic host_low = 0;
   logic drv_low, drv_high, pin_in;

   assign pin_in = ~(host_low | drv_low);

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_ack_ctrl #(.SYNC_LOW_MIN(P_MIN), .ACK_LOW(P_ACK), .SYNC_WAIT(P_WAIT),
                  .SYNC_REPLY(P_REPLY)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_ack_on(c_on), .cmd_ack_off(c_off),
      .cmd_read(c_rd), .cmd_write(c_wr), .cmd_bkgd(c_bk), .cmd_go(c_go),
      .cmd_go_until(c_gu), .cmd_trace1(c_tr), .wr_data_done(e_wr),
      .bus_done(e_bus), .cpu_enter_bg(e_in), .cpu_exit_bg(e_out),
      .pin_in(pin_in), .drv_low(drv_low), .drv_high(drv_high)
   );

   int total = 0, bad = 0;
   string cur_req = "R1";
   bit done = 0;

   // reference model: pending list as a queue of strings, output phase timeline
   bit    m_en;
   string m_pend[$];
   bit    m_wr, m_bus, m_want;
   int    m_phase, m_left, m_low;

   function automatic bit is_rc(string k);
      return k == "bkgd" || k == "go" || k == "gou_run" || k == "gou_wait" || k == "trace";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_pend.delete(); m_wr = 0; m_bus = 0; m_want = 0;
         m_phase = 0; m_left = 0; m_low = 0;
      end else begin
         bit idle, hit, take, fire, pin;
         string k;
         idle = (m_phase == 0);
         pin  = ~host_low;
         hit  = idle && pin && (m_low >= P_MIN);
         take = idle && m_want && !hit;
         fire = 0;
         k = (m_pend.size() != 0) ? m_pend[0] : "";
         if (m_en && (c_rd || c_wr || c_bk || c_go || c_gu || c_tr)) begin
            m_pend.delete(); m_wr = 0; m_bus = 0;
            m_pend.push_back(c_rd ? "read" : c_wr ? "write" : c_bk ? "bkgd" :
                             c_go ? "go" : c_gu ? "gou_run" : "trace");
         end else if (hit && is_rc(k)) begin
            m_pend.delete();
         end else if (k == "read" && e_bus) begin
            fire = 1; m_pend.delete();
         end else if (k == "write") begin
            m_wr = m_wr || e_wr; m_bus = m_bus || e_bus;
            if (m_wr && m_bus) begin fire = 1; m_pend.delete(); end
         end else if ((k == "bkgd" || k == "gou_wait" || k == "trace") && e_in) begin
            fire = 1; m_pend.delete();
         end else if (k == "go" && e_out) begin
            fire = 1; m_pend.delete();
         end else if (k == "gou_run" && e_out) begin
            m_pend[0] = "gou_wait";
         end
         m_want = (m_want && !take) || fire || c_on;
         if (c_on) m_en = 1; else if (c_off) m_en = 0;
         m_low = (!idle || pin) ? 0 : ((m_low < P_MIN) ? m_low + 1 : m_low);
         case (m_phase)
            0: if (hit) begin m_phase = 3; m_left = P_WAIT; end
               else if (m_want || take) begin
                  if (take) begin m_phase = 1; m_left = P_ACK; end
               end
            1, 3, 4: begin
               m_left--;
               if (m_left == 0) begin
                  if (m_phase == 3) begin m_phase = 4; m_left = P_REPLY; end
                  else m_phase = m_phase + 1;
               end
            end
            default: m_phase = 0;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   int rises = 0;
   bit prev_low = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit el, eh;
         el = (m_phase == 1 || m_phase == 4);
         eh = (m_phase == 2 || m_phase == 5);
         total++;
         if (drv_low !== el || drv_high !== eh) begin
            bad++;
            $display("FAIL %s: drv_low/drv_high=%b%b expected %b%b at %0t",
                     cur_req, drv_low, drv_high, el, eh, $time);
         end
         if (drv_low && !prev_low) rises++;
         prev_low = drv_low;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(ref logic s);
      s = 1; step(1); s = 0;
   endtask

   task automatic expect_pulses(int n, string req);
      total++;
      if (rises != n) begin
         bad++;
         $display("FAIL %s: pulse count %0d expected %0d", req, rises, n);
      end
      rises = 0;
   endtask

   task automatic host_hold(int n);
      host_low = 1; step(n); host_low = 0;
   endtask

   initial begin
      step(3);
      // R1: reset state
      total++;
      if (drv_low !== 0 || drv_high !== 0) begin
         bad++; $display("FAIL R1: drives %b%b expected 00", drv_low, drv_high);
      end
      rst_n = 1; step(1);
      cur_req = "R1";
      strobe(c_rd); strobe(e_bus); strobe(c_bk); strobe(e_in); step(10);
      expect_pulses(0, "R1");
      cur_req = "R2";
      strobe(c_on); step(10); expect_pulses(1, "R2");
      cur_req = "R4";
      strobe(c_rd); step(2); strobe(e_bus); step(10); expect_pulses(1, "R4");
      cur_req = "R5";
      strobe(c_wr); strobe(e_bus); step(3); expect_pulses(0, "R5");
      strobe(e_wr); step(10); expect_pulses(1, "R5");
      strobe(c_wr); strobe(e_wr); step(2); strobe(e_bus); step(10);
      expect_pulses(1, "R5");
      strobe(c_wr); e_wr = 1; e_bus = 1; step(1); e_wr = 0; e_bus = 0; step(10);
      expect_pulses(1, "R5");
      cur_req = "R6";
      strobe(c_bk); step(2); strobe(e_out); step(2); strobe(e_in); step(10);
      expect_pulses(1, "R6");
      strobe(c_go); strobe(e_out); step(10); expect_pulses(1, "R6");
      cur_req = "R7";
      strobe(c_gu); strobe(e_in); step(5); expect_pulses(0, "R7");
      strobe(e_out); step(5); expect_pulses(0, "R7");
      strobe(e_in); step(10); expect_pulses(1, "R7");
      strobe(c_tr); step(3); strobe(e_in); step(10); expect_pulses(1, "R7");
      cur_req = "R9";
      strobe(c_rd); host_hold(P_MIN - 1); step(25); expect_pulses(0, "R9");
      strobe(e_bus); step(10); expect_pulses(1, "R9");
      cur_req = "R8";
      strobe(c_bk); host_hold(P_MIN); step(P_WAIT + P_REPLY + 6);
      expect_pulses(1, "R10");
      strobe(e_in); step(10); expect_pulses(0, "R8");
      strobe(c_gu); strobe(e_out); host_hold(P_MIN + 5);
      step(P_WAIT + P_REPLY + 6); strobe(e_in); step(10);
      expect_pulses(1, "R8");
      cur_req = "R2";
      strobe(c_off); strobe(c_rd); strobe(e_bus); step(10);
      expect_pulses(0, "R2");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1; total++; bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule